// File: doc/BRIEF.md
# Pre-Defined Block Count Tracker for a Memory Card

This block is the card-side controller for multiple-block transfers whose length is fixed in advance. It receives already-decoded commands, each with an index, a 32-bit argument and a flag that says whether the command CRC was good. The data path sends it one strobe each time a data block ends. From these inputs the block tracks the card state among transfer, sending-data and receive-data. It can hold a block count loaded by the set-block-count command (index 23). It applies that count to a read-multiple (index 18) or write-multiple (index 25) command, but only if that command is the very next one.

During a counted transfer the block counts down once per block. When the count is used up it returns to transfer state by itself, with no stop command. A later stop command (index 12) is still accepted without error. When no count is armed, the transfer is open-ended and ends only on a stop command. During a write the block gives a per-block commit enable, so data beyond the counted blocks never reaches memory. It also raises a response-enable pulse, with an illegal-command flag, for every command that arrives with a good CRC.

Top module: `blk_count_tracker`

## Requirements
- R1: After a synchronous active-high reset, `card_state` is 0 (transfer; 1 = sending-data, 2 = receive-data), `count_active` is 0, `r1_en` and `r1_illegal` are 0, and no count is armed.
- R2: A set-block-count command (index 23) with good CRC received outside transfer state produces `r1_en`=1 with `r1_illegal`=1 one cycle later. It arms nothing and does not change the state.
- R3: An armed count applies only when a read-multiple (18) or write-multiple (25) command is the next command presented. Any other command in between, including a status query (13), cancels it, so the transfer runs open-ended.
- R4: When several set-block-count commands are issued back to back, the count from the most recent one is the one used.
- R5: A set-block-count command whose argument bits [15:0] are zero arms nothing, and the next multi-block command runs open-ended.
- R6: A command with a bad CRC flag produces no response (`r1_en` stays 0), changes no state and cancels any armed count. After a set-block-count command with a bad CRC, the next multi-block command runs open-ended.
- R7: A set-block-count command with good CRC in transfer state produces `r1_en`=1 and `r1_illegal`=0 one cycle later, whatever the count value, including 0xFFFF.
- R8: A counted transfer loads `blocks_left` from argument bits [15:0] and sets `count_active`. It decrements once per end-of-block strobe. In the cycle after the strobe that brings the count to zero, the state is transfer and `count_active` is 0.
- R9: `wr_commit` equals `blk_done` while the state is receive-data, in the same cycle. After a counted write has finished, further block strobes give `wr_commit`=0.
- R10: A stop command (12) moves sending-data or receive-data to transfer one cycle later. In transfer state it is tolerated: `r1_en`=1, `r1_illegal`=0, and the state is unchanged.
- R11: An open-ended transfer keeps `count_active` at 0 and stays in sending-data or receive-data across any number of block strobes.
- R12: A read-multiple or write-multiple command with good CRC outside transfer state is answered with `r1_illegal`=1 and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A decoded command is presented this cycle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument; bits [15:0] carry the block count |
| cmd_crc_ok | input | 1 | Command CRC was good |
| blk_done | input | 1 | End-of-block strobe from the data path |
| card_state | output | 2 | 0 transfer, 1 sending-data, 2 receive-data |
| count_active | output | 1 | A counted transfer is in progress |
| blocks_left | output | 16 | Blocks remaining in the counted transfer |
| wr_commit | output | 1 | Commit the block now ending to memory |
| r1_en | output | 1 | Send a response for the previous command |
| r1_illegal | output | 1 | The response flags an illegal command |

## Verification
The embedded assertions check, on every cycle, the rules that can be written in local terms. A bad-CRC command stays silent. Set-block-count and late stop commands in transfer state get clean responses. The counter steps down by exactly one, never sits active at zero, and its last strobe returns the card to transfer. An open-ended transfer holds its state. The bench scenarios alone show the rules that depend on command order: one-shot arming and its cancellation by a status query, last-count-wins, zero and bad-CRC counts that fall back to open-ended, and gating of writes past the count. The random sequences check all of these against a bench model.

// File: rtl/blkcnt_pkg.sv
package blkcnt_pkg;

    localparam int IDX_W = 6;
    localparam int ARG_W = 32;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        CS_TRAN = 2'd0,
        CS_SEND = 2'd1,
        CS_RECV = 2'd2
    } card_state_e;

    localparam logic [IDX_W-1:0] CMD_STOP      = 6'd12;
    localparam logic [IDX_W-1:0] CMD_STATUS    = 6'd13;
    localparam logic [IDX_W-1:0] CMD_RD_MULTI  = 6'd18;
    localparam logic [IDX_W-1:0] CMD_SET_COUNT = 6'd23;
    localparam logic [IDX_W-1:0] CMD_WR_MULTI  = 6'd25;

    typedef struct packed {
        logic             valid;
        logic             crc_ok;
        logic [IDX_W-1:0] idx;
    } cmd_t;

    typedef struct packed {
        logic accept;
        logic arm_load;
        logic start_rd;
        logic start_wr;
        logic stop;
        logic illegal;
    } dec_t;

    function automatic logic is_xfer(card_state_e s);
        return (s == CS_SEND) || (s == CS_RECV);
    endfunction

endpackage

// File: rtl/blkcnt_decode.sv
module blkcnt_decode
    import blkcnt_pkg::*;
(
    input  cmd_t        cmd,
    input  card_state_e st,
    output dec_t        dec
);
    logic in_tran;
    assign in_tran = (st == CS_TRAN);

    always_comb begin
        dec        = '0;
        dec.accept = cmd.valid & cmd.crc_ok;
        if (dec.accept) begin
            unique case (cmd.idx)
                CMD_SET_COUNT: begin
                    dec.arm_load = in_tran;
                    dec.illegal  = ~in_tran;
                end
                CMD_RD_MULTI: begin
                    dec.start_rd = in_tran;
                    dec.illegal  = ~in_tran;
                end
                CMD_WR_MULTI: begin
                    dec.start_wr = in_tran;
                    dec.illegal  = ~in_tran;
                end
                CMD_STOP:  dec.stop = is_xfer(st);
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/blkcnt_arm.sv
module blkcnt_arm #(
    parameter int CNT_W = blkcnt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_cmd,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             armed,
    output logic [CNT_W-1:0] armed_cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            armed_cnt <= '0;
        end else if (load) begin
            armed     <= (load_val != '0);
            armed_cnt <= load_val;
        end else if (any_cmd) begin
            armed     <= 1'b0;
        end
    end

    AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        any_cmd && !load |=> !armed); // R3
    AST_ZERO_NOT_ARMED: assert property (@(posedge clk) disable iff (rst)
        load && load_val == '0 |=> !armed); // R5
endmodule

// File: rtl/blkcnt_counter.sv
module blkcnt_counter #(
    parameter int CNT_W = blkcnt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_armed,
    input  logic [CNT_W-1:0] start_cnt,
    input  logic             stop,
    input  logic             tick,
    output logic             active,
    output logic [CNT_W-1:0] left,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign last = active & tick & (left == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            left   <= '0;
        end else if (stop) begin
            active <= 1'b0;
        end else if (start) begin
            active <= start_armed;
            left   <= start_armed ? start_cnt : '0;
        end else if (tick && active) begin
            left <= left - ONE;
            if (left == ONE) active <= 1'b0;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        active && tick && !start && !stop && left > ONE
        |=> active && left == $past(left) - ONE); // R8
    AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        active |-> left != '0); // R8
endmodule

// File: rtl/blk_count_tracker.sv
module blk_count_tracker
    import blkcnt_pkg::*;
#(
    parameter int IDX_W_P = blkcnt_pkg::IDX_W,
    parameter int ARG_W_P = blkcnt_pkg::ARG_W,
    parameter int CNT_W_P = blkcnt_pkg::CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [IDX_W_P-1:0] cmd_index,
    input  logic [ARG_W_P-1:0] cmd_arg,
    input  logic               cmd_crc_ok,
    input  logic               blk_done,
    output logic [1:0]         card_state,
    output logic               count_active,
    output logic [CNT_W_P-1:0] blocks_left,
    output logic               wr_commit,
    output logic               r1_en,
    output logic               r1_illegal
);
    card_state_e state_q;
    cmd_t        cmd;
    dec_t        dec;
    logic        armed;
    logic [CNT_W_P-1:0] armed_cnt;
    logic        tick;
    logic        last;
    logic        unused_arg_hi;

    assign unused_arg_hi = ^cmd_arg[ARG_W_P-1:CNT_W_P];

    assign cmd.valid  = cmd_valid;
    assign cmd.crc_ok = cmd_crc_ok;
    assign cmd.idx    = IDX_W'(cmd_index);

    blkcnt_decode u_dec (
        .cmd (cmd),
        .st  (state_q),
        .dec (dec)
    );

    blkcnt_arm #(.CNT_W(CNT_W_P)) u_arm (
        .clk       (clk),
        .rst       (rst),
        .any_cmd   (cmd_valid),
        .load      (dec.arm_load),
        .load_val  (cmd_arg[CNT_W_P-1:0]),
        .armed     (armed),
        .armed_cnt (armed_cnt)
    );

    assign tick = blk_done & is_xfer(state_q);

    blkcnt_counter #(.CNT_W(CNT_W_P)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .start       (dec.start_rd | dec.start_wr),
        .start_armed (armed),
        .start_cnt   (armed_cnt),
        .stop        (dec.stop),
        .tick        (tick),
        .active      (count_active),
        .left        (blocks_left),
        .last        (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CS_TRAN;
            r1_en      <= 1'b0;
            r1_illegal <= 1'b0;
        end else begin
            r1_en      <= dec.accept;
            r1_illegal <= dec.illegal;
            if (dec.stop)          state_q <= CS_TRAN;
            else if (dec.start_rd) state_q <= CS_SEND;
            else if (dec.start_wr) state_q <= CS_RECV;
            else if (last)         state_q <= CS_TRAN;
        end
    end

    assign card_state = state_q;
    assign wr_commit  = blk_done & (state_q == CS_RECV);

    AST_BADCRC_SILENT: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_crc_ok |=> !r1_en && card_state == $past(card_state)); // R6
    AST_SETCNT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_crc_ok && cmd_index == CMD_SET_COUNT && card_state == 2'd0
        |=> r1_en && !r1_illegal); // R7
    AST_SETCNT_WRONG_STATE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_crc_ok && cmd_index == CMD_SET_COUNT && card_state != 2'd0
        |=> r1_illegal && card_state == $past(card_state)); // R2
    AST_AUTO_RETURN: assert property (@(posedge clk) disable iff (rst)
        count_active && blk_done && blocks_left == CNT_W_P'(1) && !cmd_valid
        |=> card_state == 2'd0 && !count_active); // R8
    AST_LATE_STOP: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_crc_ok && cmd_index == CMD_STOP && card_state == 2'd0
        |=> r1_en && !r1_illegal && card_state == 2'd0); // R10
    AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        card_state != 2'd0 && !count_active && !cmd_valid
        |=> card_state == $past(card_state)); // R11
endmodule

// File: tb/sim_blk_count_tracker.sv
`timescale 1ns/1ps
module sim_blk_count_tracker;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        cmd_crc_ok;
    logic        blk_done;
    logic [1:0]  card_state;
    logic        count_active;
    logic [15:0] blocks_left;
    logic        wr_commit;
    logic        r1_en;
    logic        r1_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model of the requirements
    int  m_state;   // 0 tran, 1 send, 2 recv
    bit  m_armv;
    int  m_armc;
    bit  m_act;
    int  m_left;
    bit  e_r1;
    bit  e_ill;

    always #4 clk = ~clk;

    blk_count_tracker u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .cmd_crc_ok(cmd_crc_ok), .blk_done(blk_done),
        .card_state(card_state), .count_active(count_active),
        .blocks_left(blocks_left), .wr_commit(wr_commit),
        .r1_en(r1_en), .r1_illegal(r1_illegal)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(tag, "card_state", int'(card_state), m_state);
        chk(tag, "count_active", int'(count_active), int'(m_act));
        if (m_act) chk(tag, "blocks_left", int'(blocks_left), m_left);
        chk(tag, "r1_en", int'(r1_en), int'(e_r1));
        chk(tag, "r1_illegal", int'(r1_illegal), int'(e_ill));
    endtask

    function automatic void model_cmd(int idx, int arg, bit crc);
        e_r1  = crc;
        e_ill = 0;
        if (!crc) begin
            m_armv = 0;
            return;
        end
        case (idx)
            23: begin
                if (m_state == 0) begin
                    m_armc = arg & 32'hFFFF;
                    m_armv = (m_armc != 0);
                end else begin
                    e_ill  = 1;
                    m_armv = 0;
                end
            end
            18, 25: begin
                if (m_state == 0) begin
                    m_state = (idx == 18) ? 1 : 2;
                    m_act   = m_armv;
                    m_left  = m_armv ? m_armc : 0;
                end else e_ill = 1;
                m_armv = 0;
            end
            12: begin
                if (m_state != 0) begin
                    m_state = 0;
                    m_act   = 0;
                end
                m_armv = 0;
            end
            default: m_armv = 0;
        endcase
    endfunction

    task automatic do_cmd(int idx, int arg, bit crc, string tag);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_index  = 6'(idx);
        cmd_arg    = 32'(arg);
        cmd_crc_ok = crc;
        model_cmd(idx, arg, crc);
        @(negedge clk);
        cmd_valid  = 1'b0;
        cmd_crc_ok = 1'b0;
        chk_all(tag);
    endtask

    task automatic do_blk(string tag);
        @(negedge clk);
        blk_done = 1'b1;
        #1;
        chk(tag, "wr_commit", int'(wr_commit), (m_state == 2) ? 1 : 0);
        if (m_state != 0 && m_act) begin
            m_left--;
            if (m_left == 0) begin
                m_act   = 0;
                m_state = 0;
            end
        end
        e_r1  = 0;
        e_ill = 0;
        @(negedge clk);
        blk_done = 1'b0;
        chk_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        rst = 1'b1; cmd_valid = 0; cmd_index = 0; cmd_arg = 0;
        cmd_crc_ok = 0; blk_done = 0;
        m_state = 0; m_armv = 0; m_armc = 0; m_act = 0; m_left = 0;
        e_r1 = 0; e_ill = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R1");
        chk("R1", "wr_commit", int'(wr_commit), 0);

        // counted write, overrun and late stop
        do_cmd(23, 3, 1, "R7");
        do_cmd(25, 0, 1, "R8");
        do_blk("R9");
        do_blk("R8");
        do_blk("R8");
        do_blk("R9");
        do_cmd(12, 0, 1, "R10");

        // status query in between cancels
        do_cmd(23, 5, 1, "R3");
        do_cmd(13, 0, 1, "R3");
        do_cmd(18, 0, 1, "R3");
        for (int i = 0; i < 4; i++) do_blk("R11");
        do_cmd(12, 0, 1, "R10");

        // last count wins
        do_cmd(23, 7, 1, "R4");
        do_cmd(23, 2, 1, "R4");
        do_cmd(18, 0, 1, "R4");
        do_blk("R4");
        do_blk("R8");

        // zero count is open-ended
        do_cmd(23, 32'h0001_0000, 1, "R5");
        do_cmd(25, 0, 1, "R5");
        do_blk("R11");
        do_blk("R9");
        do_cmd(12, 0, 1, "R10");

        // bad CRC count is not armed
        do_cmd(23, 4, 0, "R6");
        do_cmd(18, 0, 1, "R6");
        do_blk("R6");
        do_cmd(12, 0, 1, "R10");

        // large count gives a clean response
        do_cmd(23, 32'hFFFF, 1, "R7");
        do_cmd(13, 0, 1, "R3");

        // wrong-state commands
        do_cmd(18, 0, 1, "R12");
        do_cmd(23, 2, 1, "R2");
        do_cmd(25, 0, 1, "R12");
        do_cmd(12, 0, 0, "R6");
        do_cmd(12, 0, 1, "R10");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int pick;
            bit crc;
            pick = int'($urandom_range(0, 9));
            crc  = ($urandom_range(0, 7) != 0);
            case (pick)
                0, 1:    do_cmd(23, int'($urandom_range(0, 4)), crc, "R8");
                2:       do_cmd(18, 0, crc, "R3");
                3:       do_cmd(25, 0, crc, "R9");
                4:       do_cmd(12, 0, crc, "R10");
                5:       do_cmd(13, 0, crc, "R3");
                default: do_blk("R8");
            endcase
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule